// File: doc/BRIEF.md
# Burst WAIT and Data Bus Driver

This block is the memory-side output stage for synchronous burst transfers. It takes words from an internal word source, places them on a data bus and drives a WAIT pin that tells the external controller whether the bus carries valid data. The word source presents each word and its valid flag one cycle before the word's bus slot. The block registers the word onto the bus and raises an output-enable in exactly those cycles when the bus holds a valid word. In every other cycle the bus is treated as high-impedance, and the driven value is zero.

Two bits of a configuration register shape the WAIT pin. A timing bit picks one of two alignments. In the first, WAIT changes in the same cycle that bus validity changes. In the second, WAIT changes one clock earlier, which gives the controller a cycle of warning. A polarity bit picks the asserted level of WAIT. WAIT is asserted during a burst whenever the bus is not carrying a valid word, and that includes stalls in the middle of a burst. It paces read and write bursts in the same way. Outside a burst, WAIT rests at its deasserted level. A configuration write that arrives during a burst is held back and applied once the burst is over.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset the timing bit (index 8) is 1 and the polarity bit (index 10) is 1. With those values, dq_oe is 0 and wait_o is 0 (deasserted, active high).
- R2: When burst_active and src_valid are both 1 in cycle k, dq_o equals the src_data of cycle k and dq_oe is 1 in cycle k+1.
- R3: In any cycle where dq_oe is 0, dq_o is all zeros. dq_oe is 0 in cycle k+1 when src_valid or burst_active was 0 in cycle k.
- R4: With the timing bit at 1 (lead mode), during a burst WAIT is asserted in cycle k exactly when src_valid is 0 in cycle k. This is one clock before the bus goes invalid.
- R5: With the timing bit at 0 (aligned mode), during a burst WAIT is asserted in cycle k exactly when dq_oe is 0 in cycle k.
- R6: With the polarity bit at 1, asserted WAIT is 1. With the polarity bit at 0, asserted WAIT is 0 and deasserted WAIT is 1.
- R7: While burst_active is 0, wait_o sits at the deasserted level, and src_valid has no effect on dq_oe in the next cycle.
- R8: A write (cfg_we=1) made while burst_active is 0 takes effect from the next cycle. Only bits 8 and 10 of cfg_wdata matter; all other bits are ignored.
- R9: A write made while burst_active is 1 leaves the active settings unchanged until the burst ends. The most recent held write is applied in the first cycle with burst_active at 0 and takes effect from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data (bit 8 timing, bit 10 polarity) |
| burst_active | input | 1 | High for the whole of a burst, including its last bus cycle |
| src_valid | input | 1 | Source word valid, one cycle ahead of its bus slot |
| src_data | input | 16 | Source word |
| wait_o | output | 1 | WAIT pin level |
| dq_o | output | 16 | Data bus value |
| dq_oe | output | 1 | Data bus output-enable |

## Verification
A word and its output-enable reach the bus one clock after the source presents them. WAIT in aligned mode follows that registered enable in the same cycle. WAIT in lead mode depends combinationally on the source flag of the current cycle. A configuration write lands one cycle after the first idle cycle that can accept it. The driver applies stimulus on the falling edge and queues the expected values for that same cycle, taken from a model that advances one register step per edge. The monitor compares the outputs shortly after that edge, once inputs and registered state have both settled and well before the next rising edge.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef struct packed {
        logic lead;   // 1: WAIT changes one clock ahead of data validity
        logic pol;    // 1: WAIT asserted high
    } bwg_cfg_t;

    typedef struct packed {
        bwg_cfg_t act;    // settings in force
        bwg_cfg_t held;   // write deferred during a burst
        logic     pend;   // a deferred write is waiting
    } bwg_cfg_state_t;

    localparam bwg_cfg_t BWG_CFG_RESET = '{lead: 1'b1, pol: 1'b1};

endpackage

// File: rtl/bwg_cfg.sv
module bwg_cfg
    import bwg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int LEAD_BIT = 8,
    parameter int POL_BIT  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             burst_active,
    output bwg_cfg_t         cfg_act
);

    bwg_cfg_state_t st_d, st_q;
    bwg_cfg_t       wr_cfg;

    always_comb begin
        wr_cfg.lead = cfg_wdata[LEAD_BIT];
        wr_cfg.pol  = cfg_wdata[POL_BIT];
        st_d = st_q;
        if (!burst_active) begin
            if (cfg_we) begin
                st_d.act = wr_cfg;
            end else if (st_q.pend) begin
                st_d.act = st_q.held;
            end
            st_d.pend = 1'b0;
        end else if (cfg_we) begin
            st_d.held = wr_cfg;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act  <= BWG_CFG_RESET;
            st_q.held <= BWG_CFG_RESET;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_act = st_q.act;

endmodule

// File: rtl/bwg_dpath.sv
module bwg_dpath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_active,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              nxt_valid,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dq
);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] dq;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        nxt_valid = burst_active & src_valid;
        bus_d.oe  = nxt_valid;
        bus_d.dq  = nxt_valid ? src_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_oe = bus_q.oe;
    assign bus_dq = bus_q.dq;

endmodule

// File: rtl/bwg_wait.sv
module bwg_wait
    import bwg_pkg::*;
(
    input  bwg_cfg_t cfg_act,
    input  logic     burst_active,
    input  logic     nxt_valid,
    input  logic     bus_oe,
    output logic     wait_o
);

    logic asserted;

    always_comb begin
        if (!burst_active) begin
            asserted = 1'b0;
        end else if (cfg_act.lead) begin
            asserted = ~nxt_valid;
        end else begin
            asserted = ~bus_oe;
        end
        wait_o = cfg_act.pol ? asserted : ~asserted;
    end

endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
    import bwg_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 16,
    parameter int LEAD_BIT = 8,
    parameter int POL_BIT  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              burst_active,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              wait_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    bwg_cfg_t cfg_act;
    logic     nxt_valid;
    logic     cfg_lead;
    logic     cfg_pol;

    bwg_cfg #(
        .CFG_W   (CFG_W),
        .LEAD_BIT(LEAD_BIT),
        .POL_BIT (POL_BIT)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .burst_active(burst_active),
        .cfg_act     (cfg_act)
    );

    bwg_dpath #(
        .DATA_W(DATA_W)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_active(burst_active),
        .src_valid   (src_valid),
        .src_data    (src_data),
        .nxt_valid   (nxt_valid),
        .bus_oe      (dq_oe),
        .bus_dq      (dq_o)
    );

    bwg_wait u_wait (
        .cfg_act     (cfg_act),
        .burst_active(burst_active),
        .nxt_valid   (nxt_valid),
        .bus_oe      (dq_oe),
        .wait_o      (wait_o)
    );

    assign cfg_lead = cfg_act.lead;
    assign cfg_pol  = cfg_act.pol;

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 16,
    parameter int LEAD_BIT = 8,
    parameter int POL_BIT  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              burst_active,
    input logic              src_valid,
    input logic              wait_o,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe,
    input logic              cfg_lead,
    input logic              cfg_pol
);

    AST_OE_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && src_valid) |=> dq_oe);   // R2
    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(burst_active && src_valid) |=> !dq_oe);   // R3
    AST_BUS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0));   // R3
    AST_LEAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && cfg_lead) |-> ((wait_o == cfg_pol) != src_valid));   // R4
    AST_ALIGN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !cfg_lead) |-> ((wait_o == cfg_pol) != dq_oe));   // R5
    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> (wait_o == !cfg_pol));   // R7
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && cfg_we) |=>
            (cfg_lead == $past(cfg_wdata[LEAD_BIT]) && cfg_pol == $past(cfg_wdata[POL_BIT])));   // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |=> ($stable(cfg_lead) && $stable(cfg_pol)));   // R9

endmodule

bind burst_wait_gen bwg_checker #(
    .DATA_W  (DATA_W),
    .CFG_W   (CFG_W),
    .LEAD_BIT(LEAD_BIT),
    .POL_BIT (POL_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .burst_active(burst_active),
    .src_valid   (src_valid),
    .wait_o      (wait_o),
    .dq_o        (dq_o),
    .dq_oe       (dq_oe),
    .cfg_lead    (cfg_lead),
    .cfg_pol     (cfg_pol)
);

// File: tb/burst_wait_gen_test.sv
module burst_wait_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        burst_active = 1'b0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic        wait_o;
    logic [15:0] dq_o;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;   // 250 MHz

    burst_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .burst_active(burst_active), .src_valid(src_valid), .src_data(src_data),
        .wait_o(wait_o), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct {
        logic        w;
        logic        oe;
        logic [15:0] dq;
        string       wtag;
        string       btag;
    } exp_t;

    exp_t exp_q[$];

    // bench model of the requirements
    logic        m_lead = 1'b1, m_pol = 1'b1;
    logic        m_oe = 1'b0;
    logic [15:0] m_dq = '0;
    logic        m_pend = 1'b0, m_hlead = 1'b1, m_hpol = 1'b1;
    logic [15:0] word_ctr = 16'h1000;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic ba, input logic we, input logic [15:0] wd,
                         input logic sv, input string note);
        exp_t e;
        logic asrt;
        @(negedge clk);
        burst_active = ba;
        cfg_we       = we;
        cfg_wdata    = wd;
        src_valid    = sv;
        word_ctr     = word_ctr + 16'h0111;
        src_data     = word_ctr;
        asrt   = ba && (m_lead ? !sv : !m_oe);
        e.w    = m_pol ? asrt : !asrt;
        e.oe   = m_oe;
        e.dq   = m_dq;
        e.wtag = {(!m_pol) ? "R6" : (!ba ? "R7" : (m_lead ? "R4" : "R5")), note};
        e.btag = {m_oe ? "R2" : "R3", note};
        exp_q.push_back(e);
        // advance model by one edge
        m_oe = ba && sv;
        m_dq = (ba && sv) ? word_ctr : 16'h0;
        if (!ba) begin
            if (we) begin
                m_lead = wd[8];
                m_pol  = wd[10];
            end else if (m_pend) begin
                m_lead = m_hlead;
                m_pol  = m_hpol;
            end
            m_pend = 1'b0;
        end else if (we) begin
            m_pend  = 1'b1;
            m_hlead = wd[8];
            m_hpol  = wd[10];
        end
    endtask

    task automatic run_burst(input logic [11:0] pat, input int n, input string note);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 16'h0, pat[i], note);
        cycle(1'b1, 1'b0, 16'h0, 1'b0, note);   // last bus slot drains
        cycle(1'b0, 1'b0, 16'h0, 1'b1, {note, " R7 idle"});
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.wtag, " wait"}, {15'h0, wait_o}, {15'h0, e.w});
                check({e.btag, " oe"}, {15'h0, dq_oe}, {15'h0, e.oe});
                check({e.btag, " dq"}, dq_o, e.dq);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset oe", {15'h0, dq_oe}, 16'h0);
        check("R1 reset wait", {15'h0, wait_o}, 16'h0);
        rst_n = 1'b1;
        // idle with valid flags: ignored (R7)
        cycle(1'b0, 1'b0, 16'h0, 1'b1, " R7 idle");
        cycle(1'b0, 1'b0, 16'h0, 1'b1, " R7 idle");
        // default lead mode, active high (R1, R4)
        run_burst(12'b0000_1110_1100, 9, " R1 default");
        // aligned mode, active high; other bits set and ignored (R8)
        cycle(1'b0, 1'b1, 16'hFEFF, 1'b0, " R8 write");
        run_burst(12'b0000_1110_1100, 9, " R8 aligned");
        // lead mode, active low (R6)
        cycle(1'b0, 1'b1, 16'h0100, 1'b0, " R8 write");
        run_burst(12'b0011_0110_1010, 10, " R6 lead low");
        // writes during a burst are held; latest wins (R9)
        cycle(1'b1, 1'b1, 16'h0000, 1'b1, " R9 held");
        cycle(1'b1, 1'b0, 16'h0000, 1'b0, " R9 held");
        cycle(1'b1, 1'b1, 16'h0400, 1'b1, " R9 held");
        cycle(1'b1, 1'b0, 16'h0000, 1'b1, " R9 held");
        cycle(1'b1, 1'b0, 16'h0000, 1'b0, " R9 held");
        cycle(1'b0, 1'b0, 16'h0000, 1'b0, " R9 apply");
        cycle(1'b0, 1'b0, 16'h0000, 1'b0, " R9 applied");
        run_burst(12'b0001_1011_0110, 9, " R9 aligned high");
        // aligned mode, active low (R5, R6)
        cycle(1'b0, 1'b1, 16'hFAFF, 1'b0, " R8 write");
        run_burst(12'b0111_1001_1100, 11, " R5 aligned low");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL monitor: actual %0d pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

endmodule